// File: doc/BRIEF.md
# Exception Acceptance Deferral Unit

This block sits beside an instruction decoder and decides, once for every decoded slot, whether a waiting exception source may be taken now or must be held. Three sources are tracked: a bus error, an external interrupt and a floating-point exception. The decoder supplies a class tag for the instruction decoded just before the current slot. A small per-class, per-source table then decides which sources are eligible in that slot.

A source that is refused is kept in a pending bit and is not lost. It is taken at the first valid decode whose predecessor class allows it. At most one source is granted per slot, chosen by fixed priority. The grant appears as a one-cycle pulse on a one-hot accept vector.

A control state machine with three states tracks the slot outcome:
- `ST_EMPTY`: nothing is pending.
- `ST_HOLD`: at least one source is held, and no grant was given.
- `ST_TAKE`: an accept pulse is driven in this cycle.

The transitions are taken at every clock edge:
- Any grant leads to `ST_TAKE`.
- Otherwise, remaining pending sources lead to `ST_HOLD`.
- Otherwise the machine goes to `ST_EMPTY`.

Top module: `exc_defer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all pending bits and the accept vector become 0 by the following cycle.
- R2: Source vector bit positions are: bit 0 bus error, bit 1 floating-point exception, bit 2 interrupt. `prev_class` 2'b00 (ordinary) makes all three sources eligible. A grant decided at an edge with `dec_valid` high shows on `acc_vec` for exactly the next cycle.
- R3: `prev_class` 2'b01 (delayed branch) makes no source eligible, so `acc_vec` stays 0 after that slot.
- R4: `prev_class` 2'b10 (interrupt-disabled, i.e. control/system register load or store) refuses bus error and interrupt but allows the floating-point exception.
- R5: `prev_class` 2'b11 (FPU instruction) refuses bus error and interrupt but allows the floating-point exception.
- R6: Among eligible sources, bus error wins over floating-point exception, which wins over interrupt. `acc_vec` has at most one bit set.
- R7: A refused source stays pending and is accepted at the first valid decode whose class allows it.
- R8: With `dec_valid` low no accept is issued. Pending bits hold their values, and new requests are still latched.
- R9: A request for a source that is already pending merges into the same bit and yields a single accept.
- R10: A floating-point request raised together with `fpx_xfer` high (a data-transfer FP instruction) is ignored.
- R11: A pending bit clears only at the edge where its grant is given, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A decoded instruction occupies this slot |
| prev_class | input | 2 | Class of the preceding instruction |
| req_berr | input | 1 | Bus error request |
| req_irq | input | 1 | External interrupt request |
| req_fpx | input | 1 | Floating-point exception request |
| fpx_xfer | input | 1 | Current FP operation is a data transfer; masks `req_fpx` |
| acc_vec | output | 3 | One-hot accept pulse (bit 0 bus error, 1 FP, 2 interrupt) |
| pend_vec | output | 3 | Held sources, same bit order |

## Verification
Two things can happen in the same cycle. A fresh request can arrive at the edge where the same source's held bit is granted. Alternatively, one source can be granted while a different one is newly refused and parked.

The bench provokes the first case by re-raising a held interrupt in its accept slot. It then judges that exactly one pulse appears and the bit ends cleared.

It provokes the second case with all three sources under an interrupt-disabled class. It then expects the floating-point grant while bus error and interrupt remain pending.

// File: rtl/exc_defer_pkg.sv
package exc_defer_pkg;

    localparam int SRC_N    = 3;
    localparam int CLS_W    = 2;
    localparam int SRC_BERR = 0;
    localparam int SRC_FPX  = 1;
    localparam int SRC_IRQ  = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN   = 2'b00,
        CLS_DBRANCH = 2'b01,
        CLS_NOINT   = 2'b10,
        CLS_FLOAT   = 2'b11
    } insn_cls_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_HOLD  = 2'b01,
        ST_TAKE  = 2'b10
    } slot_st_e;

endpackage

// File: rtl/exc_defer_policy.sv
module exc_defer_policy
    import exc_defer_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  insn_cls_e      cls,
    output logic [N-1:0]   allow
);
    // Per-source eligibility table: the FP source survives every class but
    // the delayed branch; the others need an ordinary predecessor.
    for (genvar s = 0; s < N; s++) begin : g_src
        if (s == SRC_FPX) begin : g_fpx
            always_comb begin
                unique case (cls)
                    CLS_PLAIN:   allow[s] = 1'b1;
                    CLS_DBRANCH: allow[s] = 1'b0;
                    CLS_NOINT:   allow[s] = 1'b1;
                    CLS_FLOAT:   allow[s] = 1'b1;
                    default:     allow[s] = 1'b0;
                endcase
            end
        end else begin : g_other
            always_comb begin
                unique case (cls)
                    CLS_PLAIN:   allow[s] = 1'b1;
                    default:     allow[s] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/exc_defer_arbiter.sv
module exc_defer_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Lowest index has highest priority.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_defer_pending.sv
module exc_defer_pending #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)          pend[i] <= 1'b0;
            else if (clr[i])  pend[i] <= 1'b0;
            else if (set[i])  pend[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/exc_defer_unit.sv
module exc_defer_unit
    import exc_defer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dec_valid,
    input  logic [CLS_W-1:0]     prev_class,
    input  logic                 req_berr,
    input  logic                 req_irq,
    input  logic                 req_fpx,
    input  logic                 fpx_xfer,
    output logic [SRC_N-1:0]     acc_vec,
    output logic [SRC_N-1:0]     pend_vec
);
    localparam int N = SRC_N;

    slot_st_e        state_q, state_d;
    logic [N-1:0]    req_vec, cand, allow, elig, grant, grant_q;

    // Incoming sources in priority order; FP data transfers raise nothing.
    always_comb begin
        req_vec           = '0;
        req_vec[SRC_BERR] = req_berr;
        req_vec[SRC_FPX]  = req_fpx & ~fpx_xfer;
        req_vec[SRC_IRQ]  = req_irq;
    end

    assign cand = pend_vec | req_vec;
    assign elig = cand & allow & {N{dec_valid}};

    exc_defer_policy #(.N(N)) u_policy (
        .cls   (insn_cls_e'(prev_class)),
        .allow (allow)
    );

    exc_defer_arbiter #(.N(N)) u_arb (
        .req   (elig),
        .grant (grant)
    );

    exc_defer_pending #(.N(N)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (req_vec),
        .clr  (grant),
        .pend (pend_vec)
    );

    // Next-state decision
    always_comb begin
        unique case (state_q)
            ST_EMPTY, ST_HOLD, ST_TAKE: begin
                if (|grant)               state_d = ST_TAKE;
                else if (|cand)           state_d = ST_HOLD;
                else                      state_d = ST_EMPTY;
            end
            default:                      state_d = ST_EMPTY;
        endcase
    end

    // State register with captured grant
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_TAKE:  acc_vec = grant_q;
            ST_HOLD:  acc_vec = '0;
            ST_EMPTY: acc_vec = '0;
            default:  acc_vec = '0;
        endcase
    end
endmodule

// File: rtl/exc_defer_chk.sv
module exc_defer_chk
    import exc_defer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dec_valid,
    input logic [CLS_W-1:0]   prev_class,
    input logic               req_berr,
    input logic               req_irq,
    input logic               req_fpx,
    input logic               fpx_xfer,
    input logic [SRC_N-1:0]   acc_vec,
    input logic [SRC_N-1:0]   pend_vec
);
    p_single_acc_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_vec));

    p_no_acc_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> (acc_vec == '0));

    p_branch_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && prev_class == 2'b01) |=> (acc_vec == '0));

    p_noint_fpx_only_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && prev_class == 2'b10) |=> (!acc_vec[0] && !acc_vec[2]));

    p_float_fpx_only_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && prev_class == 2'b11) |=> (!acc_vec[0] && !acc_vec[2]));

    p_clear_on_acc_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_vec) & ~pend_vec & ~acc_vec) == '0);

    p_acc_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_vec & ~($past(pend_vec) |
                     {$past(req_irq), $past(req_fpx & ~fpx_xfer), $past(req_berr)})) == '0);
endmodule

bind exc_defer_unit exc_defer_chk u_chk (.*);

// File: tb/exc_defer_unit_bench.sv
module exc_defer_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [1:0] prev_class = 2'b00;
    logic       req_berr = 1'b0, req_irq = 1'b0, req_fpx = 1'b0, fpx_xfer = 1'b0;
    logic [2:0] acc_vec, pend_vec;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    localparam logic [1:0] PLAIN = 2'b00, DBR = 2'b01, NOINT = 2'b10, FLT = 2'b11;
    // bit 0 bus error, bit 1 FP, bit 2 interrupt
    localparam logic [2:0] B = 3'b001, F = 3'b010, I = 3'b100, Z = 3'b000;

    always #10 clk = ~clk;   // 50 MHz

    exc_defer_unit u_exc_defer_unit (.*);

    // Drive at negedge, apply one edge, sample at next negedge.
    task automatic slot(input logic v, input logic [1:0] c, input logic [2:0] r,
                        input logic x);
        dec_valid = v; prev_class = c;
        req_berr = r[0]; req_fpx = r[1]; req_irq = r[2]; fpx_xfer = x;
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0; req_berr = 1'b0; req_fpx = 1'b0; req_irq = 1'b0; fpx_xfer = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [2:0] ea, input logic [2:0] ep);
        n_chk++;
        if (acc_vec !== ea || pend_vec !== ep) begin
            n_bad++;
            $display("FAIL %s acc=%b pend=%b expected acc=%b pend=%b",
                     tag, acc_vec, pend_vec, ea, ep);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        slot(1'b1, PLAIN, B | I, 1'b0);
        rst = 1'b0;
        chk("R1 reset", Z, Z);
    endtask

    task automatic t_plain;
        slot(1'b1, PLAIN, I, 1'b0);  chk("R2 plain irq", I, Z);
        slot(1'b0, PLAIN, Z, 1'b0);  chk("R2 pulse one cycle", Z, Z);
    endtask

    task automatic t_branch;
        slot(1'b1, DBR, B, 1'b0);    chk("R3 branch refuses", Z, B);
        slot(1'b1, PLAIN, Z, 1'b0);  chk("R7 held berr taken", B, Z);
    endtask

    task automatic t_noint_float;
        slot(1'b1, NOINT, B | F | I, 1'b0); chk("R4 noint takes fpx", F, B | I);
        slot(1'b1, FLT, Z, 1'b0);           chk("R5 float refuses berr/irq", Z, B | I);
        slot(1'b1, FLT, F, 1'b0);           chk("R5 float takes fpx", F, B | I);
        slot(1'b0, PLAIN, Z, 1'b0);         chk("R8 no valid holds", Z, B | I);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R6 berr before irq", B, I);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R7 irq taken later", I, Z);
    endtask

    task automatic t_prio;
        slot(1'b1, PLAIN, F | I, 1'b0);     chk("R6 fpx before irq", F, I);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R6 irq next", I, Z);
    endtask

    task automatic t_merge;
        slot(1'b1, DBR, I, 1'b0);           chk("R9 first irq held", Z, I);
        slot(1'b1, DBR, I, 1'b0);           chk("R9 repeat merges", Z, I);
        slot(1'b1, PLAIN, I, 1'b0);         chk("R9 single accept", I, Z);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R9 no second accept", Z, Z);
    endtask

    task automatic t_xfer;
        slot(1'b1, PLAIN, F, 1'b1);         chk("R10 xfer fpx ignored", Z, Z);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R10 still nothing", Z, Z);
    endtask

    task automatic t_stall;
        slot(1'b0, PLAIN, I, 1'b0);         chk("R8 latched without valid", Z, I);
        slot(1'b0, PLAIN, Z, 1'b0);         chk("R11 held through stall", Z, I);
        slot(1'b1, NOINT, Z, 1'b0);         chk("R11 held when refused", Z, I);
        slot(1'b1, PLAIN, Z, 1'b0);         chk("R11 clears on accept", I, Z);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_plain();
        t_branch();
        t_noint_float();
        t_prio();
        t_merge();
        t_xfer();
        t_stall();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule